// File: doc/BRIEF.md
# Rectifier start-up sequencing controller

This block steps a three-phase boost rectifier from the moment power is applied to regulated operation. It does not measure anything, filter anything or generate PWM. It watches a digitised output-voltage word and two level words. The first level is roughly the mean line-to-line voltage. The second is the output reference. It also watches two protection flags and a one-cycle tick that arrives once per switching period. From these it drives the inrush-relay coil, the bridge switching enable, a soft-start launch request, the voltage-loop gain selection and a hold-off line to the downstream converter.

The sequence has three timed steps. First comes passive charging through the series resistors, with every switch off and the relays open. Once the output reaches the mean line level, a long hold-off follows. The relays then close and a settling wait runs. After that, switching starts, the duty-cycle soft start is launched and the bank boosts to its reference. During the whole sequence, the voltage loop runs on its fast gain set and the downstream converter is kept off. When the output reaches the reference, the block moves to regulated operation: it releases the load and returns the loop to its steady-state gain.

Either protection flag sends the block into a latched fault state from any step. The same fault state is entered if charging does not reach the mean line level within a timeout. Only a reset leaves the fault state. All delays are counted in switching ticks and are parameters.

Top module: `rect_startup_seq`

## Requirements
- R1: After reset, the outputs are as follows: relay_on=0, bridge_en=0, softstart_go=0, gain_fast=1, load_hold=1, fault=0.
- R2: While vout is below avg_thr and fewer than PRECHG_TIMEOUT_TICKS ticks have elapsed, relay_on and bridge_en stay 0.
- R3: vout greater than or equal to avg_thr in the charging step starts a hold-off. relay_on is still 0 after HOLDOFF_TICKS-1 ticks. It rises within two clocks of the HOLDOFF_TICKS-th tick.
- R4: After the relay closes, bridge_en rises on the second clock edge after the SETTLE_TICKS-th tick. softstart_go is 1 only in the first cycle that bridge_en is 1.
- R5: During boosting, vout below vref keeps the block boosting. vout greater than or equal to vref moves it, one clock later, to regulated operation with load_hold=0 and gain_fast=0 while bridge_en stays 1.
- R6: gain_fast and load_hold are 1 in every state except regulated operation.
- R7: oc_flag=1 or ov_flag=1 in any state gives fault=1, bridge_en=0, softstart_go=0 and load_hold=1 at the next clock.
- R8: fault, once set, stays 1 whatever the inputs do, until rst_n is asserted.
- R9: If vout stays below avg_thr, the PRECHG_TIMEOUT_TICKS-th tick of the charging step leads to fault=1 within two clocks. After PRECHG_TIMEOUT_TICKS-1 ticks, fault is still 0.
- R10: Once relay_on is 1, it stays 1 until reset, including in the fault state. A fault taken before the relay closes leaves it open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One-cycle pulse per switching period |
| vout | input | VW | Digitised output voltage |
| avg_thr | input | VW | Level of the mean line-to-line voltage that ends passive charging |
| vref | input | VW | Output voltage reference that ends start-up |
| oc_flag | input | 1 | Input over-current indication |
| ov_flag | input | 1 | Output over-voltage indication |
| relay_on | output | 1 | Inrush relay drive, 1 closes the relays |
| bridge_en | output | 1 | Enables bridge switching |
| softstart_go | output | 1 | One-cycle request to launch the duty-cycle ramp |
| gain_fast | output | 1 | 1 selects the high-bandwidth voltage-loop gains |
| load_hold | output | 1 | 1 keeps the downstream converter off |
| fault | output | 1 | Latched protection or timeout fault |

## Verification
The checker tests several rules on every cycle:
- A protection flag forces the fault outputs at the next edge.
- The fault and a closed relay never release.
- The bridge never runs with the relay open.
- The launch request is a single cycle tied to the bridge enable rising.
- A released load always comes with fast gain off and switching on.

Two kinds of property need the bench's directed and randomised scenarios. The first is the exact tick counts of the hold-off, settling and timeout windows, including their off-by-one edges. The second is the equality boundaries on the two voltage comparisons.

// File: rtl/rss_pkg.sv
package rss_pkg;
  typedef enum logic [2:0] {
    ST_CHARGE  = 3'd0,
    ST_HOLDOFF = 3'd1,
    ST_BYPASS  = 3'd2,
    ST_BOOST   = 3'd3,
    ST_RUN     = 3'd4,
    ST_FAULT   = 3'd5
  } rss_state_e;

  localparam int LVL_AVG = 0;
  localparam int LVL_REF = 1;
  localparam int N_LVL   = 2;
endpackage

// File: rtl/rss_tick_timer.sv
module rss_tick_timer #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_en;

  assign done   = (cnt_q >= limit);
  assign cnt_en = clr | (tick & ~done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= clr ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rss_vcheck.sv
module rss_vcheck #(
  parameter int VW    = 12,
  parameter int N_LVL = 2
) (
  input  logic [VW-1:0]            vout,
  input  logic [N_LVL-1:0][VW-1:0] lvl,
  output logic [N_LVL-1:0]         ge
);
  for (genvar gi = 0; gi < N_LVL; gi++) begin : g_cmp
    assign ge[gi] = (vout >= lvl[gi]);
  end
endmodule

// File: rtl/rss_fsm.sv
module rss_fsm
  import rss_pkg::*;
#(
  parameter int CNT_W                = 17,
  parameter int PRECHG_TIMEOUT_TICKS = 100000,
  parameter int HOLDOFF_TICKS        = 20000,
  parameter int SETTLE_TICKS         = 5000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prot,
  input  logic             at_avg,
  input  logic             at_ref,
  input  logic             tmr_done,
  output logic             tmr_clr,
  output logic [CNT_W-1:0] tmr_limit,
  output rss_state_e       state,
  output logic             relay_q,
  output logic             ss_q
);
  localparam logic [CNT_W-1:0] LIM_CHARGE  = CNT_W'(PRECHG_TIMEOUT_TICKS);
  localparam logic [CNT_W-1:0] LIM_HOLDOFF = CNT_W'(HOLDOFF_TICKS);
  localparam logic [CNT_W-1:0] LIM_SETTLE  = CNT_W'(SETTLE_TICKS);

  rss_state_e state_q, state_d;
  logic       relay_set, ss_d;

  always_comb begin
    state_d = state_q;
    if (prot) begin
      state_d = ST_FAULT;
    end else begin
      case (state_q)
        ST_CHARGE: begin
          if (at_avg)        state_d = ST_HOLDOFF;
          else if (tmr_done) state_d = ST_FAULT;
        end
        ST_HOLDOFF: if (tmr_done) state_d = ST_BYPASS;
        ST_BYPASS:  if (tmr_done) state_d = ST_BOOST;
        ST_BOOST:   if (at_ref)   state_d = ST_RUN;
        ST_RUN:     state_d = ST_RUN;
        default:    state_d = ST_FAULT;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_CHARGE:  tmr_limit = LIM_CHARGE;
      ST_HOLDOFF: tmr_limit = LIM_HOLDOFF;
      ST_BYPASS:  tmr_limit = LIM_SETTLE;
      default:    tmr_limit = '0;
    endcase
  end

  assign tmr_clr   = (state_d != state_q);
  assign relay_set = (state_q == ST_HOLDOFF) && (state_d == ST_BYPASS);
  assign ss_d      = (state_q == ST_BYPASS) && (state_d == ST_BOOST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CHARGE;
      ss_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ss_q    <= ss_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      relay_q <= 1'b0;
    end else if (relay_set) begin
      relay_q <= 1'b1;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/rect_startup_seq.sv
module rect_startup_seq
  import rss_pkg::*;
#(
  parameter int VW                   = 12,
  parameter int PRECHG_TIMEOUT_TICKS = 100000,
  parameter int HOLDOFF_TICKS        = 20000,
  parameter int SETTLE_TICKS         = 5000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [VW-1:0] vout,
  input  logic [VW-1:0] avg_thr,
  input  logic [VW-1:0] vref,
  input  logic          oc_flag,
  input  logic          ov_flag,
  output logic          relay_on,
  output logic          bridge_en,
  output logic          softstart_go,
  output logic          gain_fast,
  output logic          load_hold,
  output logic          fault
);
  localparam int MAX_AB = (HOLDOFF_TICKS > SETTLE_TICKS) ? HOLDOFF_TICKS : SETTLE_TICKS;
  localparam int MAX_T  = (PRECHG_TIMEOUT_TICKS > MAX_AB) ? PRECHG_TIMEOUT_TICKS : MAX_AB;
  localparam int CNT_W  = $clog2(MAX_T + 1);

  logic                    rst_meta_q, rst_sync_n;
  logic [N_LVL-1:0][VW-1:0] lvl;
  logic [N_LVL-1:0]        ge;
  logic                    tmr_clr, tmr_done, relay_q, ss_q;
  logic [CNT_W-1:0]        tmr_limit;
  rss_state_e              state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign lvl[LVL_AVG] = avg_thr;
  assign lvl[LVL_REF] = vref;

  rss_vcheck #(.VW(VW), .N_LVL(N_LVL)) vcheck_i (
    .vout (vout),
    .lvl  (lvl),
    .ge   (ge)
  );

  rss_tick_timer #(.CNT_W(CNT_W)) timer_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (tmr_clr),
    .tick  (tick),
    .limit (tmr_limit),
    .done  (tmr_done)
  );

  rss_fsm #(
    .CNT_W                (CNT_W),
    .PRECHG_TIMEOUT_TICKS (PRECHG_TIMEOUT_TICKS),
    .HOLDOFF_TICKS        (HOLDOFF_TICKS),
    .SETTLE_TICKS         (SETTLE_TICKS)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .prot      (oc_flag | ov_flag),
    .at_avg    (ge[LVL_AVG]),
    .at_ref    (ge[LVL_REF]),
    .tmr_done  (tmr_done),
    .tmr_clr   (tmr_clr),
    .tmr_limit (tmr_limit),
    .state     (state),
    .relay_q   (relay_q),
    .ss_q      (ss_q)
  );

  assign relay_on     = relay_q;
  assign bridge_en    = (state == ST_BOOST) || (state == ST_RUN);
  assign softstart_go = ss_q && (state == ST_BOOST);
  assign gain_fast    = (state != ST_RUN);
  assign load_hold    = (state != ST_RUN);
  assign fault        = (state == ST_FAULT);
endmodule

// File: rtl/rss_checker.sv
module rss_checker (
  input logic clk,
  input logic rst_n,
  input logic oc_flag,
  input logic ov_flag,
  input logic relay_on,
  input logic bridge_en,
  input logic softstart_go,
  input logic gain_fast,
  input logic load_hold,
  input logic fault
);
  p_prot_trip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_flag || ov_flag) |=> (fault && !bridge_en && !softstart_go && load_hold));

  p_fault_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  p_relay_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    relay_on |=> relay_on);

  p_bridge_after_relay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bridge_en |-> relay_on);

  p_ss_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    softstart_go |=> !softstart_go);

  p_ss_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bridge_en) |-> softstart_go);

  p_release_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_hold |-> (bridge_en && !fault));

  p_gain_tracks_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gain_fast == load_hold);
endmodule

bind rect_startup_seq rss_checker chk_i (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .oc_flag      (oc_flag),
  .ov_flag      (ov_flag),
  .relay_on     (relay_on),
  .bridge_en    (bridge_en),
  .softstart_go (softstart_go),
  .gain_fast    (gain_fast),
  .load_hold    (load_hold),
  .fault        (fault)
);

// File: tb/rect_startup_seq_tb_top.sv
module rect_startup_seq_tb_top;
  localparam int VW   = 12;
  localparam int TOUT = 30;
  localparam int HOLD = 8;
  localparam int SETL = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          oc = 1'b0;
  logic          ov = 1'b0;
  logic [VW-1:0] vout = '0;
  logic [VW-1:0] thr = 12'd200;
  logic [VW-1:0] vref = 12'd400;
  logic          relay_on, bridge_en, softstart_go, gain_fast, load_hold, fault;
  logic [5:0]    outv;
  int            n_chk = 0;
  int            n_fail = 0;
  bit            finished = 1'b0;

  always #2 clk = ~clk;

  rect_startup_seq #(
    .VW(VW), .PRECHG_TIMEOUT_TICKS(TOUT), .HOLDOFF_TICKS(HOLD), .SETTLE_TICKS(SETL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .vout(vout), .avg_thr(thr), .vref(vref),
    .oc_flag(oc), .ov_flag(ov), .relay_on(relay_on), .bridge_en(bridge_en),
    .softstart_go(softstart_go), .gain_fast(gain_fast), .load_hold(load_hold), .fault(fault)
  );

  assign outv = {relay_on, bridge_en, softstart_go, gain_fast, load_hold, fault};

  // expected {relay, bridge, softstart, gain_fast, load_hold, fault} per step
  function automatic logic [5:0] exp_vec(int ph, bit rly);
    case (ph)
      0, 1:    return 6'b000110;
      2:       return 6'b100110;
      3:       return 6'b110110;
      4:       return 6'b110000;
      default: return {rly, 5'b00111};
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick = 1'b0; oc = 1'b0; ov = 1'b0; vout = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) pulse_tick();
  endtask

  task automatic pick_levels();
    thr  = VW'(100 + $urandom % 200);
    vref = thr + VW'(50 + $urandom % 100);
  endtask

  task automatic advance(int ph);
    pick_levels();
    if (ph >= 1) begin
      vout = thr;
      @(negedge clk);
      @(negedge clk);
    end
    if (ph >= 2) ticks(HOLD);
    if (ph >= 3) ticks(SETL);
    if (ph >= 4) begin
      vout = vref;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h5eed_0042);
    do_reset();
    chk("R1 reset outputs", 32'(outv), 32'(exp_vec(0, 0)));

    // nominal sequence
    pick_levels();
    for (int k = 0; k < 5; k++) begin
      vout = VW'($urandom % thr);
      pulse_tick();
      chk("R2 charging below level", 32'(outv), 32'(exp_vec(0, 0)));
    end
    vout = thr - 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 one count below level", 32'(outv), 32'(exp_vec(0, 0)));
    vout = thr;
    @(negedge clk);
    @(negedge clk);
    ticks(HOLD - 1);
    chk("R3 relay open before hold-off end", 32'(outv), 32'(exp_vec(1, 0)));
    pulse_tick();
    chk("R3 relay closed after hold-off", 32'(outv), 32'(exp_vec(2, 1)));
    ticks(SETL - 1);
    chk("R4 bridge off before settle end", 32'(outv), 32'(exp_vec(2, 1)));
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    chk("R4 bridge still off one edge after tick", 32'(bridge_en), 32'd0);
    @(negedge clk);
    chk("R4 bridge on with soft-start pulse", 32'(outv), 32'(exp_vec(3, 1) | 6'b001000));
    @(negedge clk);
    chk("R4 soft-start pulse ends", 32'(outv), 32'(exp_vec(3, 1)));
    vout = vref - 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 boosting below reference", 32'(outv), 32'(exp_vec(3, 1)));
    vout = vref;
    @(negedge clk);
    chk("R5 R6 regulated at reference", 32'(outv), 32'(exp_vec(4, 1)));
    oc = 1'b1;
    @(negedge clk);
    chk("R7 over-current trip in regulation", 32'(outv), 32'(exp_vec(5, 1)));
    oc = 1'b0;
    vout = '0;
    repeat (10) @(negedge clk);
    chk("R8 R10 fault and relay latched", 32'(outv), 32'(exp_vec(5, 1)));
    do_reset();
    chk("R8 reset clears fault", 32'(outv), 32'(exp_vec(0, 0)));

    // charging timeout
    thr = 12'd4000;
    vout = 12'd10;
    ticks(TOUT - 1);
    chk("R9 no fault before timeout", 32'(outv), 32'(exp_vec(0, 0)));
    pulse_tick();
    chk("R9 timeout fault", 32'(outv), 32'(exp_vec(5, 0)));

    // randomised protection events in every step
    for (int i = 0; i < 14; i++) begin
      int ph;
      do_reset();
      ph = $urandom % 5;
      advance(ph);
      chk("R6 step outputs before trip", 32'(outv), 32'(exp_vec(ph, 0)));
      if ($urandom % 2 == 0) ov = 1'b1; else oc = 1'b1;
      @(negedge clk);
      chk("R7 trip from random step", 32'(outv), 32'(exp_vec(5, ph >= 2)));
      oc = 1'b0; ov = 1'b0;
      vout = VW'($urandom);
      repeat (5) @(negedge clk);
      chk("R10 relay kept as at trip", 32'(outv), 32'(exp_vec(5, ph >= 2)));
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #600000;
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule